// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error Flags and Request-to-Send

The block recovers asynchronous serial characters from a single receive line. The line idles high. A character is a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit, and one or two high stop bits. A 16x bit-rate tick paces sampling. Every falling edge seen while idle begins a new character, so the receiver re-aligns itself to each frame. Received bytes enter a 64-entry first-in first-out store. The consumer reads it through a show-ahead port: the oldest entry is always visible, and a read strobe removes it.

Four sticky error flags report conditions on the line: overrun, parity mismatch, bad stop bit and line break. A status-read strobe clears all of them. An active-low request-to-send output throttles the far transmitter from the free space in the store, with a dead band at the midpoint. A timeout flag tells the consumer that bytes are waiting while the line has gone quiet.

Top module: `uart_rx_top`

## Requirements
- R1: A falling edge on the synchronised line while idle starts a character. The line is checked again on the 8th tick after the edge. If the line is high there, the event is discarded and nothing is stored.
- R2: The data-length code sets the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7, 11 gives 8. Each bit is sampled once, 16 ticks after the previous sample. The first bit received is bit 0, and unused upper bits read as 0.
- R3: The parity code's bit 2 enables the parity bit. The codes are 100 odd, 101 even, 110 always 1, 111 always 0. A mismatch sets the sticky parity flag, and the byte is still stored.
- R4: A low sample in any stop-bit position (one or two, as selected) sets the sticky framing flag, unless the frame is a break. The byte is still stored.
- R5: A frame whose start, data, parity and stop samples are all low is a break. It stores one entry with data 0 and the break marker set, and it sets the break flag but not the framing flag. The next character is only accepted after the line returns high.
- R6: A character that completes while the store holds 64 entries is dropped, and the sticky overrun flag is set.
- R7: Error flags stay set until a status-read strobe. The strobe clears them; a new error in the same cycle wins over the strobe.
- R8: The store keeps 64 entries in arrival order. The read port shows the oldest entry, and a read strobe removes it. The data-ready output is high exactly while at least one entry is held. A read strobe on an empty store does nothing.
- R9: With flow control enabled, the request-to-send output is driven low while more than 32 entries are free and high while fewer than 32 are free. At exactly 32 free it holds its last value. With flow control off it stays low.
- R10: The timeout flag is high while the store is non-empty and 4 character times have passed since the last start edge. A character time is 16 ticks per bit of the configured frame. The flag falls when the store empties or a new start edge arrives.
- R11: After reset the store is empty, all flags are low, and the request-to-send output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idle high |
| tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| data_len_i | input | 2 | Data-length code (00=5 .. 11=8 bits) |
| parity_i | input | 3 | Parity code (0xx none, 100 odd, 101 even, 110 one, 111 zero) |
| two_stop_i | input | 1 | Two stop bits when high |
| flow_en_i | input | 1 | Enables request-to-send throttling |
| rd_en_i | input | 1 | Removes the oldest stored entry |
| status_rd_i | input | 1 | Clears the sticky error flags |
| rd_data_o | output | 8 | Oldest stored byte |
| rd_break_o | output | 1 | Oldest entry was produced by a break |
| data_ready_o | output | 1 | Store holds at least one entry |
| overrun_o | output | 1 | Sticky overrun flag |
| parity_err_o | output | 1 | Sticky parity flag |
| framing_err_o | output | 1 | Sticky framing flag |
| break_o | output | 1 | Sticky break flag |
| timeout_o | output | 1 | Data waiting on a quiet line |
| rts_no | output | 1 | Request-to-send, active low |

## Verification
The hardest states to reach are the overrun and the request-to-send dead band, because both need the store nearly or completely full. The stimulus sends 65 well-formed characters with no reads in between. Request-to-send is sampled after the 31st, 32nd and 33rd stores, and again during one-by-one draining, to cover the hold at exactly 32 free entries in both directions. Break, glitch and timeout each use long stretches of held line levels, with checks placed before and after the threshold instants.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRK
  } rx_state_e;

  typedef struct packed {
    logic       brk;
    logic [7:0] data;
  } rx_entry_t;

  function automatic logic [3:0] data_len(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction
endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  input  logic       tick_i,
  input  logic [1:0] data_len_i,
  input  logic [2:0] parity_i,
  input  logic       two_stop_i,
  output logic       start_o,
  output logic       push_o,
  output rx_entry_t  entry_o,
  output logic       par_err_o,
  output logic       frm_err_o,
  output logic       brk_o
);
  localparam int CW   = $clog2(OSR);
  localparam int HALF = OSR / 2;

  rx_state_e      state_q;
  logic [CW-1:0]  tcnt_q;
  logic [2:0]     bit_q;
  logic [7:0]     shift_q;
  logic           par_q, stop_idx_q, zero_q, frm_bad_q;
  logic           rx_meta_q, rx_s_q, rx_prev_q;

  logic [3:0] nbits;
  logic       fall, sample, last_stop, done, is_brk, exp_par;
  logic [7:0] aligned;

  // two-stage synchroniser plus edge history
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_meta_q <= 1'b1;
      rx_s_q    <= 1'b1;
      rx_prev_q <= 1'b1;
    end else begin
      rx_meta_q <= rx_i;
      rx_s_q    <= rx_meta_q;
      rx_prev_q <= rx_s_q;
    end
  end

  assign nbits     = data_len(data_len_i);
  assign fall      = rx_prev_q & ~rx_s_q;
  assign sample    = tick_i && (tcnt_q == CW'(OSR - 1));
  assign last_stop = !two_stop_i || stop_idx_q;
  assign done      = (state_q == ST_STOP) && sample && last_stop;
  assign is_brk    = zero_q && !rx_s_q;
  assign aligned   = shift_q >> (4'd8 - nbits);

  always_comb begin
    unique case (parity_i[1:0])
      2'b00:   exp_par = ~^aligned;
      2'b01:   exp_par = ^aligned;
      2'b10:   exp_par = 1'b1;
      default: exp_par = 1'b0;
    endcase
  end

  assign start_o      = (state_q == ST_IDLE) && fall;
  assign push_o       = done;
  assign brk_o        = done && is_brk;
  assign entry_o.brk  = is_brk;
  assign entry_o.data = is_brk ? 8'h00 : aligned;
  assign frm_err_o    = done && !is_brk && (frm_bad_q || !rx_s_q);
  assign par_err_o    = done && !is_brk && parity_i[2] && (par_q != exp_par);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      tcnt_q     <= '0;
      bit_q      <= '0;
      shift_q    <= '0;
      par_q      <= 1'b0;
      stop_idx_q <= 1'b0;
      zero_q     <= 1'b0;
      frm_bad_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (fall) begin
          state_q   <= ST_START;
          tcnt_q    <= '0;
          zero_q    <= 1'b1;
          frm_bad_q <= 1'b0;
        end
        ST_START: if (tick_i) begin
          if (tcnt_q == CW'(HALF - 1)) begin
            tcnt_q  <= '0;
            bit_q   <= '0;
            state_q <= rx_s_q ? ST_IDLE : ST_DATA;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        ST_DATA: if (tick_i) begin
          tcnt_q <= tcnt_q + 1'b1;
          if (sample) begin
            shift_q <= {rx_s_q, shift_q[7:1]};
            if (rx_s_q) zero_q <= 1'b0;
            if (bit_q == 3'(nbits - 4'd1)) begin
              state_q    <= parity_i[2] ? ST_PAR : ST_STOP;
              stop_idx_q <= 1'b0;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        ST_PAR: if (tick_i) begin
          tcnt_q <= tcnt_q + 1'b1;
          if (sample) begin
            par_q <= rx_s_q;
            if (rx_s_q) zero_q <= 1'b0;
            state_q    <= ST_STOP;
            stop_idx_q <= 1'b0;
          end
        end
        ST_STOP: if (tick_i) begin
          tcnt_q <= tcnt_q + 1'b1;
          if (sample) begin
            if (rx_s_q) zero_q <= 1'b0;
            else        frm_bad_q <= 1'b1;
            if (last_stop) state_q <= is_brk ? ST_BRK : ST_IDLE;
            else           stop_idx_q <= 1'b1;
          end
        end
        ST_BRK: if (rx_s_q) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [CW-1:0]    count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q;
  logic             do_wr, do_rd;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_wr   = wr_i && !full_o;
  assign do_rd   = rd_i && !empty_o;
  assign rdata_o = mem_q[rp_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_wr) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_rd) rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      unique case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_flow.sv
module uart_rx_flow #(
  parameter int DEPTH     = 64,
  parameter int RTS_LEVEL = 32,
  parameter int OSR       = 16,
  parameter int TO_CHARS  = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int TW = $clog2(TO_CHARS * OSR * 12 + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] count_i,
  input  logic          empty_i,
  input  logic          flow_en_i,
  input  logic          tick_i,
  input  logic          start_i,
  input  logic [1:0]    data_len_i,
  input  logic          par_en_i,
  input  logic          two_stop_i,
  output logic          rts_no,
  output logic          timeout_o
);
  logic [CW-1:0] free;
  logic          rts_q;
  logic [TW-1:0] limit, to_cnt_q;
  logic [3:0]    fbits;

  assign free = CW'(DEPTH) - count_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        rts_q <= 1'b0;
    else if (!flow_en_i)                rts_q <= 1'b0;
    else if (free > CW'(RTS_LEVEL))     rts_q <= 1'b0;
    else if (free < CW'(RTS_LEVEL))     rts_q <= 1'b1;
  end
  assign rts_no = rts_q;

  // start + data + parity + stops, in bits
  assign fbits = 4'd7 + {2'b00, data_len_i} + {3'b000, par_en_i} + {3'b000, two_stop_i};
  assign limit = TW'(TO_CHARS * OSR) * TW'(fbits);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         to_cnt_q <= '0;
    else if (start_i)                    to_cnt_q <= '0;
    else if (tick_i && to_cnt_q < limit) to_cnt_q <= to_cnt_q + 1'b1;
  end
  assign timeout_o = !empty_i && (to_cnt_q >= limit);
endmodule

// File: rtl/uart_rx_top.sv
module uart_rx_top
  import uart_rx_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int OSR       = 16,
  parameter int RTS_LEVEL = 32,
  parameter int TO_CHARS  = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  input  logic       tick_i,
  input  logic [1:0] data_len_i,
  input  logic [2:0] parity_i,
  input  logic       two_stop_i,
  input  logic       flow_en_i,
  input  logic       rd_en_i,
  input  logic       status_rd_i,
  output logic [7:0] rd_data_o,
  output logic       rd_break_o,
  output logic       data_ready_o,
  output logic       overrun_o,
  output logic       parity_err_o,
  output logic       framing_err_o,
  output logic       break_o,
  output logic       timeout_o,
  output logic       rts_no
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          start, push, perr, ferr, brk, full, empty;
  rx_entry_t     wentry, rentry;
  logic [CW-1:0] fifo_cnt;
  logic          ovr_q, par_q, frm_q, brk_q;

  uart_rx_frame #(.OSR(OSR)) u_frame (
    .clk_i, .rst_ni, .rx_i, .tick_i, .data_len_i, .parity_i, .two_stop_i,
    .start_o(start), .push_o(push), .entry_o(wentry),
    .par_err_o(perr), .frm_err_o(ferr), .brk_o(brk)
  );

  uart_rx_fifo #(.WIDTH($bits(rx_entry_t)), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .wr_i(push), .wdata_i(wentry), .rd_i(rd_en_i),
    .rdata_o(rentry), .count_o(fifo_cnt), .full_o(full), .empty_o(empty)
  );

  uart_rx_flow #(
    .DEPTH(DEPTH), .RTS_LEVEL(RTS_LEVEL), .OSR(OSR), .TO_CHARS(TO_CHARS)
  ) u_flow (
    .clk_i, .rst_ni, .count_i(fifo_cnt), .empty_i(empty), .flow_en_i,
    .tick_i, .start_i(start), .data_len_i, .par_en_i(parity_i[2]),
    .two_stop_i, .rts_no, .timeout_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q <= 1'b0;
      par_q <= 1'b0;
      frm_q <= 1'b0;
      brk_q <= 1'b0;
    end else begin
      ovr_q <= (ovr_q & ~status_rd_i) | (push & full);
      par_q <= (par_q & ~status_rd_i) | perr;
      frm_q <= (frm_q & ~status_rd_i) | ferr;
      brk_q <= (brk_q & ~status_rd_i) | brk;
    end
  end

  assign rd_data_o     = rentry.data;
  assign rd_break_o    = rentry.brk;
  assign data_ready_o  = !empty;
  assign overrun_o     = ovr_q;
  assign parity_err_o  = par_q;
  assign framing_err_o = frm_q;
  assign break_o       = brk_q;
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          flow_en_i,
  input logic          rd_en_i,
  input logic          status_rd_i,
  input logic          rts_no,
  input logic          data_ready_o,
  input logic          overrun_o,
  input logic          framing_err_o,
  input logic          break_o,
  input logic          timeout_o,
  input logic [CW-1:0] cnt
);
  // R9
  rts_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flow_en_i && $past(flow_en_i) && cnt >= CW'(DEPTH - 30)) |-> rts_no);
  // R9
  rts_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flow_en_i && $past(flow_en_i) && cnt <= CW'(DEPTH - 34)) |-> !rts_no);
  // R6
  overrun_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(cnt) == CW'(DEPTH));
  // R7
  overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(overrun_o) && !$past(status_rd_i)) |-> overrun_o);
  // R7
  break_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(break_o) && !$past(status_rd_i)) |-> break_o);
  // R5
  break_not_framing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(break_o) |-> !$rose(framing_err_o));
  // R8
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && cnt == '0) |=> cnt <= CW'(1));
  // R10
  timeout_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> data_ready_o);
endmodule

bind uart_rx_top uart_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .flow_en_i(flow_en_i), .rd_en_i(rd_en_i),
  .status_rd_i(status_rd_i), .rts_no(rts_no), .data_ready_o(data_ready_o),
  .overrun_o(overrun_o), .framing_err_o(framing_err_o), .break_o(break_o),
  .timeout_o(timeout_o), .cnt(fifo_cnt)
);

// File: tb/tb_uart_rx_top.sv
module tb_uart_rx_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_i = 1'b1;
  logic       tick_i = 1'b0;
  logic [1:0] data_len_i = 2'b11;
  logic [2:0] parity_i = 3'b000;
  logic       two_stop_i = 1'b0;
  logic       flow_en_i = 1'b1;
  logic       rd_en_i = 1'b0;
  logic       status_rd_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       rd_break_o, data_ready_o, overrun_o, parity_err_o;
  logic       framing_err_o, break_o, timeout_o, rts_no;
  logic [1:0] tdiv = '0;
  int         n_chk = 0;
  int         n_bad = 0;
  logic [25:0] v;

  localparam int BITCLK = 64; // 16 ticks x 4 clocks

  // {data, len, parity, two_stop, bad_par, bad_stop, exp_data, exp_perr, exp_ferr}
  localparam logic [25:0] VEC [8] = '{
    {8'hA5, 2'b11, 3'b000, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},
    {8'h3C, 2'b10, 3'b100, 1'b0, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0},
    {8'hFF, 2'b00, 3'b101, 1'b0, 1'b0, 1'b0, 8'h1F, 1'b0, 1'b0},
    {8'h5A, 2'b01, 3'b110, 1'b1, 1'b0, 1'b0, 8'h1A, 1'b0, 1'b0},
    {8'h81, 2'b11, 3'b111, 1'b0, 1'b0, 1'b0, 8'h81, 1'b0, 1'b0},
    {8'h96, 2'b11, 3'b101, 1'b0, 1'b1, 1'b0, 8'h96, 1'b1, 1'b0},
    {8'h0F, 2'b11, 3'b000, 1'b0, 1'b0, 1'b1, 8'h0F, 1'b0, 1'b1},
    {8'h00, 2'b11, 3'b100, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1}
  };

  uart_rx_top dut (
    .clk_i(clk), .rst_ni, .rx_i, .tick_i, .data_len_i, .parity_i, .two_stop_i,
    .flow_en_i, .rd_en_i, .status_rd_i, .rd_data_o, .rd_break_o, .data_ready_o,
    .overrun_o, .parity_err_o, .framing_err_o, .break_o, .timeout_o, .rts_no
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick_i <= (tdiv == 2'd2);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    rx_i = b;
    wait_clk(BITCLK);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic [1:0] len, input logic [2:0] pm,
                            input logic ts, input logic bad_par, input logic bad_stop);
    int nb;
    logic [7:0] m;
    logic p;
    nb = 5 + int'(len);
    m  = d & ((8'h01 << nb) - 8'h01);
    data_len_i = len;
    parity_i   = pm;
    two_stop_i = ts;
    send_bit(1'b0);
    for (int i = 0; i < nb; i++) send_bit(m[i]);
    if (pm[2]) begin
      case (pm[1:0])
        2'b00:   p = ~^m;
        2'b01:   p = ^m;
        2'b10:   p = 1'b1;
        default: p = 1'b0;
      endcase
      send_bit(p ^ bad_par);
    end
    send_bit(!bad_stop);
    if (ts) send_bit(1'b1);
    send_bit(1'b1);
  endtask

  task automatic pop();
    rd_en_i = 1'b1;
    wait_clk(1);
    rd_en_i = 1'b0;
    wait_clk(2);
  endtask

  task automatic clear_status();
    status_rd_i = 1'b1;
    wait_clk(1);
    status_rd_i = 1'b0;
    wait_clk(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait_clk(5);
    rst_ni = 1'b1;
    wait_clk(3);
    // R11 reset state
    chk("R11 data_ready", data_ready_o, 0);
    chk("R11 flags", {overrun_o, parity_err_o, framing_err_o, break_o, timeout_o}, 0);
    chk("R11 rts_n", rts_no, 0);

    // R2 R3 R4 R8 R7 vector walk
    for (int k = 0; k < 8; k++) begin
      v = VEC[k];
      send_frame(v[25:18], v[17:16], v[15:13], v[12], v[11], v[10]);
      chk("R8 data_ready", data_ready_o, 1);
      chk("R2 rd_data", rd_data_o, v[9:2]);
      chk("R3 parity_err", parity_err_o, v[1]);
      chk("R4 framing_err", framing_err_o, v[0]);
      chk("R5 no break", {rd_break_o, break_o}, 0);
      pop();
      chk("R8 empty after pop", data_ready_o, 0);
      clear_status();
      chk("R7 flags cleared", {parity_err_o, framing_err_o}, 0);
    end

    // R1 glitch rejected
    data_len_i = 2'b11; parity_i = 3'b000; two_stop_i = 1'b0;
    rx_i = 1'b0;
    wait_clk(12);
    rx_i = 1'b1;
    wait_clk(20 * BITCLK);
    chk("R1 glitch stores nothing", data_ready_o, 0);
    chk("R1 glitch no flags", {framing_err_o, break_o, parity_err_o}, 0);
    // R1 good frame after glitch
    send_frame(8'h6E, 2'b11, 3'b000, 1'b0, 1'b0, 1'b0);
    chk("R1 frame after glitch", rd_data_o, 8'h6E);
    pop();

    // R5 break
    rx_i = 1'b0;
    wait_clk(12 * BITCLK);
    chk("R5 one break entry while low", data_ready_o, 1);
    wait_clk(4 * BITCLK);
    rx_i = 1'b1;
    wait_clk(3 * BITCLK);
    chk("R5 break data", rd_data_o, 8'h00);
    chk("R5 break marker", rd_break_o, 1);
    chk("R5 break flag", break_o, 1);
    chk("R5 no framing flag", framing_err_o, 0);
    pop();
    chk("R5 single entry", data_ready_o, 0);
    // R7 sticky until status read
    chk("R7 break still set", break_o, 1);
    clear_status();
    chk("R7 break cleared", break_o, 0);

    // R10 timeout: 4 x 10 bits x 16 ticks x 4 clocks = 2560 clocks after start edge
    send_frame(8'h42, 2'b11, 3'b000, 1'b0, 1'b0, 1'b0);
    wait_clk(1700);
    chk("R10 no timeout yet", timeout_o, 0);
    wait_clk(300);
    chk("R10 timeout", timeout_o, 1);
    pop();
    chk("R10 timeout falls on empty", timeout_o, 0);

    // R6 R9 fill, overrun, drain
    for (int k = 1; k <= 64; k++) begin
      send_frame(8'(k), 2'b11, 3'b000, 1'b0, 1'b0, 1'b0);
      if (k == 31) chk("R9 rts low at 33 free", rts_no, 0);
      if (k == 32) chk("R9 rts holds low at 32 free", rts_no, 0);
      if (k == 33) chk("R9 rts high at 31 free", rts_no, 1);
    end
    chk("R6 no overrun when just full", overrun_o, 0);
    send_frame(8'hEE, 2'b11, 3'b000, 1'b0, 1'b0, 1'b0);
    chk("R6 overrun", overrun_o, 1);
    flow_en_i = 1'b0;
    wait_clk(2);
    chk("R9 rts low when disabled", rts_no, 0);
    flow_en_i = 1'b1;
    wait_clk(2);
    chk("R9 rts high when full", rts_no, 1);
    clear_status();
    chk("R7 overrun cleared", overrun_o, 0);
    for (int k = 1; k <= 64; k++) begin
      if (rd_data_o !== 8'(k)) chk("R8 order", rd_data_o, 8'(k));
      pop();
      if (k == 32) chk("R9 rts holds high at 32 free", rts_no, 1);
      if (k == 33) chk("R9 rts low at 33 free", rts_no, 0);
    end
    chk("R8 order end", rd_data_o === 8'h40 || !data_ready_o, 1);
    chk("R6 dropped byte absent", data_ready_o, 0);
    // R8 read on empty does nothing
    pop();
    chk("R8 empty read", data_ready_o, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule